// File: doc/BRIEF.md
# Prioritized Sequence-Break Controller

This block arbitrates break requests among a fixed chain of prioritized channels for a simple 36-bit processor. Each channel has a request latch. Three sources can set it: a device completion pulse, a request issued by the program, and an external signal. When the processor reaches an instruction boundary, breaks are enabled, and the highest pending channel outranks every sequence now running, the controller accepts that channel. It then takes over the memory port for a fixed hardware save.

The save takes three consecutive write cycles. They store the accumulator, the in-out register, and a packed word to three fixed slots of the accepted channel. The packed word carries the program counter in its upper half and the indirect-address field in its lower half. In the cycle after the last write, the controller forces the next fetch to the channel's fourth slot, which normally holds a jump to the service routine. A running sequence can itself be broken by a higher-priority channel, so the controller keeps a mask of nested active sequences. A dedicated return jump, issued through the channel's saved-PC slot, retires the innermost sequence and lets lower-priority channels compete again.

Top module: `seq_break_ctrl`

## Requirements
- R1: While synchronous reset is asserted and in the first idle cycle after it, the controller has no pending requests and no active sequences. `busy`, `mem_we` and `fetch_ovr` are 0 and `active_mask` is 0.
- R2: A one-cycle pulse on any of `dev_done[n]`, `prog_req[n]` or `ext_req[n]` sets channel n pending. The request stays pending until that channel's break is accepted, including while the controller is busy saving another channel.
- R3: A break is accepted only in a cycle where `brk_en` is 1, `instr_boundary` is 1, `busy` is 0 and `ret_jump` is 0. Otherwise pending requests wait and `busy` stays 0.
- R4: Channel 0 has the highest priority. Among pending channels, the lowest index is chosen. It is accepted only if no sequence is active, or if its index is strictly lower than the lowest active index.
- R5: After acceptance of channel n, the controller makes three consecutive write cycles (`mem_we`=1). They go to address 4n with the accumulator, 4n+1 with the in-out register, and 4n+2 with {PC, IA}, PC in bits 35:18. All three values are those present on the inputs in the accepting cycle.
- R6: In the cycle right after the third write, `fetch_ovr` is 1 for one cycle with `fetch_addr` = 4n+3, and `busy` then falls.
- R7: `ret_addr` is 4c+2, where c is the lowest active channel. A `ret_jump` pulse while idle clears bit c of `active_mask`.
- R8: Acceptance of channel n sets `active_mask[n]` and clears the channel's pending request. The clear happens unless a new request for the same channel arrives in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| brk_en | input | 1 | Global enable for new breaks |
| instr_boundary | input | 1 | Processor is between instructions |
| ret_jump | input | 1 | Processor executes the sequence-return jump |
| dev_done | input | 16 | Device completion pulses, one per channel |
| prog_req | input | 16 | Program-issued break requests |
| ext_req | input | 16 | External break signals |
| ac_in | input | 36 | Accumulator contents |
| io_in | input | 36 | In-out register contents |
| pc_in | input | 18 | Program counter |
| ia_in | input | 18 | Indirect-address field |
| busy | output | 1 | Save in progress; processor must hold |
| mem_we | output | 1 | Memory write strobe for a save cycle |
| mem_addr | output | 18 | Save slot address |
| mem_wdata | output | 36 | Save data |
| fetch_ovr | output | 1 | Forces the next fetch address |
| fetch_addr | output | 18 | Vector slot address |
| active_mask | output | 16 | Nested active sequences |
| ret_addr | output | 18 | Saved-PC slot of the innermost sequence |

## Verification
The embedded properties check the following on every cycle:
- the order of the three save writes and the vector cycle that follows them;
- that pending requests survive until acceptance;
- that no break starts while disabled;
- that the vectored channel is always the innermost active one;
- that each return removes exactly one active bit.

Only the bench's scenarios show the rest:
- the saved data values, taken from the inputs in the accepting cycle;
- the per-channel address arithmetic across all sixteen channels;
- that a lower-priority request stays blocked under an active sequence and is taken once the returns unwind;
- that a request arriving mid-save is serviced afterwards.

// File: rtl/sbk_pkg.sv
package sbk_pkg;
   typedef enum logic [2:0] {
      SB_IDLE = 3'd0,
      SB_AC   = 3'd1,
      SB_IO   = 3'd2,
      SB_PCIA = 3'd3,
      SB_VEC  = 3'd4
   } sb_state_e;

   localparam int SLOT_AC   = 0;
   localparam int SLOT_IO   = 1;
   localparam int SLOT_PCIA = 2;
   localparam int SLOT_VEC  = 3;
endpackage

// File: rtl/sbk_prio_pick.sv
module sbk_prio_pick #(
   parameter int N     = 16,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/sbk_req_latch.sv
module sbk_req_latch #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] dev_done,
   input  logic [N-1:0] prog_req,
   input  logic [N-1:0] ext_req,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pending
);
   logic [N-1:0] set_v;

   generate
      for (genvar g = 0; g < N; g++) begin : g_chan
         assign set_v[g] = dev_done[g] | prog_req[g] | ext_req[g];
         always_ff @(posedge clk) begin
            if (rst)           pending[g] <= 1'b0;
            else if (set_v[g]) pending[g] <= 1'b1;
            else if (clr[g])   pending[g] <= 1'b0;
         end
      end
   endgenerate

   AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((($past(pending) & ~$past(clr)) & ~pending) == '0)); // R2
   AST_REQ_SETS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (($past(set_v) & ~pending) == '0)); // R2
endmodule

// File: rtl/sbk_save_seq.sv
module sbk_save_seq
   import sbk_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int ADDR_W = 18,
   parameter int PC_W   = 18,
   parameter int WORD_W = 36
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [IDX_W-1:0]  start_chan,
   input  logic [WORD_W-1:0] ac_in,
   input  logic [WORD_W-1:0] io_in,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [PC_W-1:0]   ia_in,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              fetch_ovr,
   output logic [ADDR_W-1:0] fetch_addr
);
   sb_state_e         state, state_nx;
   logic [IDX_W-1:0]  chan_q;
   logic [WORD_W-1:0] ac_q, io_q, pcia_q;
   logic [ADDR_W-1:0] base;

   assign base = ADDR_W'({chan_q, 2'b00});

   always_comb begin
      state_nx = state;
      case (state)
         SB_IDLE: if (start) state_nx = SB_AC;
         SB_AC:   state_nx = SB_IO;
         SB_IO:   state_nx = SB_PCIA;
         SB_PCIA: state_nx = SB_VEC;
         SB_VEC:  state_nx = SB_IDLE;
         default: state_nx = SB_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= SB_IDLE;
         chan_q <= '0;
         ac_q   <= '0;
         io_q   <= '0;
         pcia_q <= '0;
      end else begin
         state <= state_nx;
         if (start && state == SB_IDLE) begin
            chan_q <= start_chan;
            ac_q   <= ac_in;
            io_q   <= io_in;
            pcia_q <= {pc_in, ia_in};
         end
      end
   end

   always_comb begin
      mem_we    = 1'b0;
      mem_addr  = base;
      mem_wdata = '0;
      case (state)
         SB_AC:   begin mem_we = 1'b1; mem_addr = base + ADDR_W'(SLOT_AC);   mem_wdata = ac_q;   end
         SB_IO:   begin mem_we = 1'b1; mem_addr = base + ADDR_W'(SLOT_IO);   mem_wdata = io_q;   end
         SB_PCIA: begin mem_we = 1'b1; mem_addr = base + ADDR_W'(SLOT_PCIA); mem_wdata = pcia_q; end
         default: ;
      endcase
   end

   assign fetch_ovr  = (state == SB_VEC);
   assign fetch_addr = base + ADDR_W'(SLOT_VEC);
   assign busy       = (state != SB_IDLE);

   AST_AC_THEN_IO: assert property (@(posedge clk) disable iff (rst)
      (mem_we && mem_addr[1:0] == 2'd0) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1))); // R5
   AST_IO_THEN_PCIA: assert property (@(posedge clk) disable iff (rst)
      (mem_we && mem_addr[1:0] == 2'd1) |=> (mem_we && mem_addr == $past(mem_addr) + ADDR_W'(1))); // R5
   AST_VEC_AFTER_SAVE: assert property (@(posedge clk) disable iff (rst)
      (mem_we && mem_addr[1:0] == 2'd2) |=> (fetch_ovr && !mem_we && fetch_addr == $past(mem_addr) + ADDR_W'(1))); // R6
   AST_VEC_ENDS: assert property (@(posedge clk) disable iff (rst)
      fetch_ovr |=> !busy); // R6
   AST_START_WRITES: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> (mem_we && mem_addr[1:0] == 2'd0)); // R5
endmodule

// File: rtl/seq_break_ctrl.sv
module seq_break_ctrl #(
   parameter int N_CHAN = 16,
   parameter int PC_W   = 18,
   parameter int WORD_W = 36,
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              brk_en,
   input  logic              instr_boundary,
   input  logic              ret_jump,
   input  logic [N_CHAN-1:0] dev_done,
   input  logic [N_CHAN-1:0] prog_req,
   input  logic [N_CHAN-1:0] ext_req,
   input  logic [WORD_W-1:0] ac_in,
   input  logic [WORD_W-1:0] io_in,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [PC_W-1:0]   ia_in,
   output logic              busy,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic              fetch_ovr,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic [N_CHAN-1:0] active_mask,
   output logic [ADDR_W-1:0] ret_addr
);
   localparam int IDX_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1;

   generate
      if (N_CHAN < 2)            begin : g_bad_n   $error("N_CHAN must be at least 2"); end
      if (WORD_W != 2 * PC_W)    begin : g_bad_w   $error("WORD_W must hold PC and IA"); end
      if (ADDR_W < IDX_W + 2)    begin : g_bad_a   $error("ADDR_W too narrow for slots"); end
   endgenerate

   logic [N_CHAN-1:0] pending, clr;
   logic              p_found, a_found;
   logic [IDX_W-1:0]  p_idx, a_idx;
   logic              accept, ret_take;

   sbk_req_latch #(.N(N_CHAN)) u_latch (
      .clk(clk), .rst(rst), .dev_done(dev_done), .prog_req(prog_req),
      .ext_req(ext_req), .clr(clr), .pending(pending)
   );

   sbk_prio_pick #(.N(N_CHAN), .IDX_W(IDX_W)) u_pick_pend (
      .vec(pending), .found(p_found), .idx(p_idx)
   );

   sbk_prio_pick #(.N(N_CHAN), .IDX_W(IDX_W)) u_pick_act (
      .vec(active_mask), .found(a_found), .idx(a_idx)
   );

   assign accept   = brk_en && instr_boundary && !busy && !ret_jump && p_found
                     && (!a_found || (p_idx < a_idx));
   assign ret_take = ret_jump && !busy && a_found;
   assign clr      = accept ? (N_CHAN'(1) << p_idx) : '0;
   assign ret_addr = ADDR_W'({a_idx, 2'b10});

   always_ff @(posedge clk) begin
      if (rst)           active_mask <= '0;
      else if (accept)   active_mask <= active_mask | (N_CHAN'(1) << p_idx);
      else if (ret_take) active_mask <= active_mask & ~(N_CHAN'(1) << a_idx);
   end

   sbk_save_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .PC_W(PC_W), .WORD_W(WORD_W)) u_save (
      .clk(clk), .rst(rst), .start(accept), .start_chan(p_idx),
      .ac_in(ac_in), .io_in(io_in), .pc_in(pc_in), .ia_in(ia_in),
      .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .fetch_ovr(fetch_ovr), .fetch_addr(fetch_addr)
   );

   AST_NO_BREAK_OFF: assert property (@(posedge clk) disable iff (rst)
      (!busy && (!brk_en || !instr_boundary)) |=> !busy); // R3
   AST_VEC_INNERMOST: assert property (@(posedge clk) disable iff (rst)
      fetch_ovr |-> (a_found && ADDR_W'({a_idx, 2'b11}) == fetch_addr)); // R4
   AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> ($countones(active_mask) == $countones($past(active_mask)) + 1)); // R8
   AST_RET_POP: assert property (@(posedge clk) disable iff (rst)
      (ret_jump && !busy && active_mask != '0) |=>
      ($countones(active_mask) + 1 == $countones($past(active_mask)))); // R7
   AST_BUSY_IDLE_MASK: assert property (@(posedge clk) disable iff (rst)
      busy |-> (active_mask != '0)); // R8
endmodule

// File: tb/seq_break_ctrl_bench.sv
`timescale 1ns/100ps
module seq_break_ctrl_bench;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          brk_en = 1'b1, instr_boundary = 1'b1, ret_jump = 1'b0;
   logic [N-1:0]  dev_done = '0, prog_req = '0, ext_req = '0;
   logic [35:0]   ac_in = '0, io_in = '0;
   logic [17:0]   pc_in = '0, ia_in = '0;
   logic          busy, mem_we, fetch_ovr;
   logic [17:0]   mem_addr, fetch_addr, ret_addr;
   logic [35:0]   mem_wdata;
   logic [N-1:0]  active_mask;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   seq_break_ctrl u_seq_break_ctrl (
      .clk(clk), .rst(rst), .brk_en(brk_en), .instr_boundary(instr_boundary),
      .ret_jump(ret_jump), .dev_done(dev_done), .prog_req(prog_req), .ext_req(ext_req),
      .ac_in(ac_in), .io_in(io_in), .pc_in(pc_in), .ia_in(ia_in),
      .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .fetch_ovr(fetch_ovr), .fetch_addr(fetch_addr), .active_mask(active_mask),
      .ret_addr(ret_addr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic logic [35:0] ac_of(int ch);  return 36'(ch) * 36'h1_0101 + 36'h7;  endfunction
   function automatic logic [35:0] io_of(int ch);  return ~(36'(ch) * 36'h3_0003);        endfunction
   function automatic logic [17:0] pc_of(int ch);  return 18'(ch * 7 + 100);              endfunction
   function automatic logic [17:0] ia_of(int ch);  return 18'(ch * 513 + 1);              endfunction

   task automatic load_data(input int ch);
      ac_in = ac_of(ch); io_in = io_of(ch); pc_in = pc_of(ch); ia_in = ia_of(ch);
   endtask

   task automatic raise(input int ch, input int src);
      case (src)
         0: dev_done[ch] = 1'b1;
         1: prog_req[ch] = 1'b1;
         default: ext_req[ch] = 1'b1;
      endcase
   endtask

   task automatic drop_all();
      dev_done = '0; prog_req = '0; ext_req = '0;
   endtask

   // Called at the negedge where the first save write is visible.
   task automatic check_save(input int ch);
      check(mem_we && mem_addr == 18'(4*ch), "R5", "ac slot addr", {45'd0, mem_we, mem_addr}, {45'd1, 18'(4*ch)});
      check(mem_wdata == ac_of(ch), "R5", "ac data", 64'(mem_wdata), 64'(ac_of(ch)));
      step(); drop_all();
      check(mem_we && mem_addr == 18'(4*ch+1), "R5", "io slot addr", {45'd0, mem_we, mem_addr}, {45'd1, 18'(4*ch+1)});
      check(mem_wdata == io_of(ch), "R5", "io data", 64'(mem_wdata), 64'(io_of(ch)));
      step();
      check(mem_we && mem_addr == 18'(4*ch+2), "R5", "pc slot addr", {45'd0, mem_we, mem_addr}, {45'd1, 18'(4*ch+2)});
      check(mem_wdata == {pc_of(ch), ia_of(ch)}, "R5", "pc/ia data", 64'(mem_wdata), 64'({pc_of(ch), ia_of(ch)}));
      step();
      check(fetch_ovr && !mem_we && fetch_addr == 18'(4*ch+3), "R6", "vector fetch",
            {45'd0, fetch_ovr, fetch_addr}, {45'd1, 18'(4*ch+3)});
      check(active_mask[ch], "R8", "active bit set", 64'(active_mask), 64'(N'(1) << ch));
   endtask

   task automatic do_ret(input int ch);
      check(ret_addr == 18'(4*ch+2), "R7", "return slot", 64'(ret_addr), 64'(4*ch+2));
      ret_jump = 1'b1; step(); ret_jump = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      step(); step(); step();
      check(!busy && !mem_we && !fetch_ovr && active_mask == '0, "R1", "state in reset",
            {44'd0, busy, mem_we, fetch_ovr, 1'b0, active_mask}, 64'd0);
      rst = 1'b0;
      step();
      check(!busy && active_mask == '0, "R1", "idle after reset", {47'd0, busy, active_mask}, 64'd0);

      // R2 R5 R6 R7: every channel alone, rotating request source
      for (int ch = 0; ch < N; ch++) begin
         load_data(ch);
         raise(ch, ch % 3); step(); drop_all(); step();
         check_save(ch);
         step();
         check(!busy, "R6", "busy falls after vector", 64'(busy), 64'd0);
         do_ret(ch);
         check(active_mask == '0, "R7", "mask cleared by return", 64'(active_mask), 64'd0);
      end

      // R4: nesting and blocking
      load_data(10); raise(10, 2); step(); drop_all(); step(); check_save(10); step();
      raise(12, 0); step(); drop_all(); step(); step(); step();
      check(!busy, "R4", "lower channel blocked", 64'(busy), 64'd0);
      raise(10, 1); step(); drop_all(); step(); step();
      check(!busy, "R4", "same channel does not re-break", 64'(busy), 64'd0);
      load_data(3); raise(3, 1); step(); drop_all(); step(); check_save(3); step();
      check(active_mask == 16'h0408, "R4", "nested mask", 64'(active_mask), 64'h0408);
      do_ret(3);
      check(active_mask == 16'h0400, "R7", "inner popped", 64'(active_mask), 64'h0400);
      step(); step();
      check(!busy, "R4", "still blocked under 10", 64'(busy), 64'd0);
      do_ret(10);
      // ch10 re-requested while active: pending 10 and 12, lowest index wins
      load_data(10); step();
      check_save(10); step(); do_ret(10);
      load_data(12); step();
      check_save(12); step(); do_ret(12);
      check(active_mask == '0, "R7", "unwound", 64'(active_mask), 64'd0);

      // R2: request arriving during a save is held
      load_data(5); raise(5, 0); step(); drop_all(); step();
      raise(1, 2);
      check_save(5);
      load_data(1); step(); step();
      check_save(1); step();
      check(active_mask == 16'h0022, "R2", "held request serviced", 64'(active_mask), 64'h0022);
      do_ret(1); do_ret(5);

      // R3: global enable gates breaks
      brk_en = 1'b0; load_data(7); raise(7, 1); step(); drop_all();
      step(); step(); step();
      check(!busy && active_mask == '0, "R3", "disabled no break", {47'd0, busy, active_mask}, 64'd0);
      brk_en = 1'b1; step();
      check_save(7); step(); do_ret(7);

      // R3: only at instruction boundaries
      instr_boundary = 1'b0; load_data(2); raise(2, 0); step(); drop_all();
      step(); step();
      check(!busy, "R3", "no break mid-instruction", 64'(busy), 64'd0);
      instr_boundary = 1'b1; step();
      check_save(2); step(); do_ret(2);

      // R8: accepted request cleared, no repeat break
      step(); step(); step();
      check(!busy && active_mask == '0, "R8", "pending cleared on accept", {47'd0, busy, active_mask}, 64'd0);

      report();
   end
endmodule